// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Peripheral Override

This block is an 8-pin general-purpose I/O port with three bus-visible registers: a pin-direction register, an output-data register and a read-only pin-level register. Software picks each pin's direction with a bit in the direction register. A pulse-width-modulation channel that owns a pin can take the pin over and make it drive. For the highest pin, a shutdown request forces the pin back to input. These overrides act only on the effective output enable and the output value sent to the pad. The stored register bits stay exactly as software last wrote them.

Every pin level passes through a two-flop synchronizer before the bus can read it. The pin-level register shows the synchronized levels whichever way each pin points. Software can compare the level it is driving with the level actually seen on the pin, and a difference points to an overloaded or shorted pin. A read of the data register merges two sources: the latched output value for pins that currently drive, and the synchronized level for pins that currently receive. The bus is synchronous and read data is registered. A pin change therefore shows up in read data three clock edges later.

Top module: `gpio_port_ovr`

## Requirements
- R1: After reset the direction and output-data registers hold 0, every `pin_oe` bit is 0 and `bus_rdata` is 0.
- R2: Register offsets on `bus_addr`: 0 selects output data (read/write), 1 selects pin level (read-only) and 2 selects direction (read/write). A direction bit of 1 makes its pin drive `pin_out` from the output-data register when no override applies.
- R3: When `pwm_en[i]` is 1, pin i drives (`pin_oe[i]`=1) with `pin_out[i]`=`pwm_wave[i]`, and the direction register reads back unchanged. The one exception is pin 7 during shutdown (R4).
- R4: While `shutdown_en` is 1, `pin_oe[7]` is 0 whatever direction bit 7 and `pwm_en[7]` say. Pins 0 to 6 are unaffected and the stored direction bit 7 is unchanged.
- R5: A read at offset 1 returns the synchronized pin levels for all pins in either direction. A pin change that is stable before clock edge k appears on `bus_rdata` after edge k+2, not earlier.
- R6: A read at offset 0 returns, per pin, the output-data register bit when that pin's effective output enable is 1, and the synchronized pin level otherwise.
- R7: The direction register can be written and read back at any time, with a written value returned bit for bit.
- R8: Offset 3 reads as 0. Writes to offsets 1 and 3 change no register.
- R9: `bus_rdata` is registered: it shows the register chosen by `bus_addr` at the previous rising edge and does not follow `bus_addr` between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register offset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pwm_en | input | 8 | Per-pin PWM channel enable |
| pwm_wave | input | 8 | Per-pin PWM waveform level |
| shutdown_en | input | 1 | Emergency shutdown for pin 7 |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_oe | output | 8 | Effective pad output enable |
| pin_out | output | 8 | Pad output value |

## Verification
The assertions assume that `bus_addr`, `bus_we`, `bus_wdata`, `pwm_en`, `pwm_wave` and `shutdown_en` change only away from the rising clock edge and belong to the clock domain. `pin_in` may change at any time. The synchronizer assertion only compares its output with the input value sampled two edges earlier. The bench changes every input on the falling edge. It drives `pin_in` from a model of the pads that resolves the block's own drive against an optional external forced level, so short-circuit stimulus stays within that assumption.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] OFS_DATA   = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_LEVEL  = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 2'd2;
  localparam logic [ADDR_W-1:0] OFS_UNUSED = 2'd3;

  // Effective drive for one pin: direction or PWM claim, vetoed by kill
  function automatic logic pin_drive_en(input logic dir_b, input logic pwm_b,
                                        input logic kill_b);
    return (dir_b | pwm_b) & ~kill_b;
  endfunction

  // Pad value for one pin
  function automatic logic pin_drive_val(input logic pwm_b, input logic wave_b,
                                         input logic latch_b);
    return pwm_b ? wave_b : latch_b;
  endfunction

  // Data-register view for one pin
  function automatic logic data_view(input logic oe_b, input logic latch_b,
                                     input logic sync_b);
    return oe_b ? latch_b : sync_b;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
    end
  end

  assign sync_out = stab_q;

  // Edges since reset, saturating, so the latency check never looks before reset
  logic [1:0] fill_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= 2'd0;
    else if (fill_q != 2'd2) fill_q <= fill_q + 2'd1;
  end

  AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q == 2'd2) |-> (sync_out == $past(async_in, 2))); // R5

endmodule

// File: rtl/gpio_ovr_ctrl.sv
module gpio_ovr_ctrl #(
  parameter int WIDTH    = 8,
  parameter int SHDN_PIN = WIDTH - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] dir_bits,
  input  logic [WIDTH-1:0] latch_bits,
  input  logic [WIDTH-1:0] pwm_en,
  input  logic [WIDTH-1:0] pwm_wave,
  input  logic             shutdown_en,
  output logic [WIDTH-1:0] eff_oe,
  output logic [WIDTH-1:0] eff_out
);
  import gpio_port_pkg::*;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic kill;
    if (i == SHDN_PIN) begin : g_shdn
      assign kill = shutdown_en;

      AST_SHDN_FORCES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_en |-> !eff_oe[i]); // R4
    end else begin : g_plain
      assign kill = 1'b0;

      AST_NO_SHDN_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_bits[i] | pwm_en[i]) |-> eff_oe[i]); // R4
    end

    assign eff_oe[i]  = pin_drive_en(dir_bits[i], pwm_en[i], kill);
    assign eff_out[i] = pin_drive_val(pwm_en[i], pwm_wave[i], latch_bits[i]);

    AST_PWM_CLAIMS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_en[i] && !kill) |-> (eff_oe[i] && (eff_out[i] == pwm_wave[i]))); // R3

    AST_DIR_DRIVES_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_bits[i] && !pwm_en[i] && !kill) |-> (eff_oe[i] && (eff_out[i] == latch_bits[i]))); // R2
  end

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile #(
  parameter int WIDTH = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [gpio_port_pkg::ADDR_W-1:0] addr,
  input  logic                             we,
  input  logic [WIDTH-1:0]                 wdata,
  input  logic [WIDTH-1:0]                 pin_sync,
  input  logic [WIDTH-1:0]                 eff_oe,
  output logic [WIDTH-1:0]                 latch_q,
  output logic [WIDTH-1:0]                 dir_q,
  output logic [WIDTH-1:0]                 rdata
);
  import gpio_port_pkg::*;

  logic wr_data;
  logic wr_dir;
  assign wr_data = we && (addr == OFS_DATA);
  assign wr_dir  = we && (addr == OFS_DIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      if (wr_data) latch_q <= wdata;
      if (wr_dir)  dir_q   <= wdata;
    end
  end

  logic [WIDTH-1:0] merged_view;
  for (genvar i = 0; i < WIDTH; i++) begin : g_view
    assign merged_view[i] = data_view(eff_oe[i], latch_q[i], pin_sync[i]);
  end

  logic [WIDTH-1:0] rd_next;
  always_comb begin
    unique case (addr)
      OFS_DATA:  rd_next = merged_view;
      OFS_LEVEL: rd_next = pin_sync;
      OFS_DIR:   rd_next = dir_q;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_next;
  end

  // One edge seen since reset: $past is meaningful from here on
  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  AST_DIR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(dir_q)); // R7

  AST_DIR_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (dir_q == $past(wdata))); // R7

  AST_LATCH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data |=> $stable(latch_q)); // R8

  AST_UNUSED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && ($past(addr) == OFS_UNUSED)) |-> (rdata == '0)); // R8

  AST_LEVEL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && ($past(addr) == OFS_LEVEL)) |-> (rdata == $past(pin_sync))); // R5

endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr #(
  parameter int N_PINS   = 8,
  parameter int SHDN_PIN = N_PINS - 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [gpio_port_pkg::ADDR_W-1:0] bus_addr,
  input  logic                             bus_we,
  input  logic [N_PINS-1:0]                bus_wdata,
  output logic [N_PINS-1:0]                bus_rdata,
  input  logic [N_PINS-1:0]                pwm_en,
  input  logic [N_PINS-1:0]                pwm_wave,
  input  logic                             shutdown_en,
  input  logic [N_PINS-1:0]                pin_in,
  output logic [N_PINS-1:0]                pin_oe,
  output logic [N_PINS-1:0]                pin_out
);

  logic [N_PINS-1:0] lvl_sync;
  logic [N_PINS-1:0] latch_bits;
  logic [N_PINS-1:0] dir_bits;
  logic [N_PINS-1:0] oe_eff;
  logic [N_PINS-1:0] out_eff;

  gpio_in_sync #(.WIDTH(N_PINS)) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (lvl_sync)
  );

  gpio_ovr_ctrl #(.WIDTH(N_PINS), .SHDN_PIN(SHDN_PIN)) i_ovr (
    .clk         (clk),
    .rst_n       (rst_n),
    .dir_bits    (dir_bits),
    .latch_bits  (latch_bits),
    .pwm_en      (pwm_en),
    .pwm_wave    (pwm_wave),
    .shutdown_en (shutdown_en),
    .eff_oe      (oe_eff),
    .eff_out     (out_eff)
  );

  gpio_regfile #(.WIDTH(N_PINS)) i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .we       (bus_we),
    .wdata    (bus_wdata),
    .pin_sync (lvl_sync),
    .eff_oe   (oe_eff),
    .latch_q  (latch_bits),
    .dir_q    (dir_bits),
    .rdata    (bus_rdata)
  );

  assign pin_oe  = oe_eff;
  assign pin_out = out_eff;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (pin_oe == '0)); // R1

endmodule

// File: tb/test_gpio_port_ovr.sv
module test_gpio_port_ovr;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pwm_en = 8'h00;
  logic [7:0] pwm_wave = 8'h00;
  logic       shutdown_en = 1'b0;
  logic [7:0] pin_in;
  logic [7:0] pin_oe;
  logic [7:0] pin_out;

  // Pad model: an external forced level wins, else own drive, else pulled low
  logic [7:0] frc_en = 8'h00;
  logic [7:0] frc_val = 8'h00;
  assign pin_in = (frc_en & frc_val) | (~frc_en & pin_oe & pin_out);

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Bench shadow of software-visible state
  logic [7:0] m_dir = 8'h00;
  logic [7:0] m_data = 8'h00;

  always #4 clk = ~clk;

  gpio_port_ovr i_gpio_port_ovr (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_en(pwm_en),
    .pwm_wave(pwm_wave), .shutdown_en(shutdown_en), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out)
  );

  function automatic logic [7:0] want_oe();
    logic [7:0] drv = m_dir | pwm_en;
    if (shutdown_en) drv[7] = 1'b0;
    return drv;
  endfunction

  function automatic logic [7:0] want_out();
    logic [7:0] v = m_data;
    for (int i = 0; i < 8; i++) if (pwm_en[i]) v[i] = pwm_wave[i];
    return v;
  endfunction

  function automatic logic [7:0] want_level();
    logic [7:0] lv = 8'h00;
    logic [7:0] oe = want_oe();
    logic [7:0] o  = want_out();
    for (int i = 0; i < 8; i++) lv[i] = frc_en[i] ? frc_val[i] : (oe[i] & o[i]);
    return lv;
  endfunction

  function automatic logic [7:0] want_data_read();
    logic [7:0] oe = want_oe();
    logic [7:0] lv = want_level();
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = oe[i] ? m_data[i] : lv[i];
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    ticks(1);
    bus_we = 1'b0;
    if (a == 2'd0) m_data = d;
    if (a == 2'd2) m_dir = d;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    ticks(1);
    v = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 rdata", bus_rdata, 8'h00);
    check("R1 pin_oe", pin_oe, 8'h00);
    rd(2'd2, v); check("R1 dir", v, 8'h00);
    rd(2'd0, v); check("R1 data", v, 8'h00);
  endtask

  task automatic t_dir_drive();
    logic [7:0] v;
    wr(2'd0, 8'hA5);
    wr(2'd2, 8'h0F);
    check("R2 pin_oe", pin_oe, 8'h0F);
    check("R2 pin_out", pin_out, 8'hA5);
    frc_en = 8'hF0; frc_val = 8'hC0;
    ticks(4);
    rd(2'd0, v); check("R6 merged data", v, want_data_read());
    rd(2'd1, v); check("R5 level", v, 8'hC5);
    // short on driven pin 0: level low, data register still 1
    frc_en = 8'hF1; frc_val = 8'hC0;
    ticks(4);
    rd(2'd1, v); check("R5 short level", v, 8'hC4);
    rd(2'd0, v); check("R6 short data", v, 8'hC5);
    frc_en = 8'h00;
    ticks(4);
  endtask

  task automatic t_pwm();
    logic [7:0] v;
    pwm_en = 8'h30; pwm_wave = 8'h10;
    ticks(1);
    check("R3 pin_oe", pin_oe, 8'h3F);
    check("R3 pin_out", pin_out, 8'h95);
    rd(2'd2, v); check("R3 dir kept", v, 8'h0F);
    ticks(4);
    rd(2'd0, v); check("R6 pwm data", v, want_data_read());
    pwm_en = 8'h00; pwm_wave = 8'h00;
    ticks(1);
    check("R3 released", pin_oe, 8'h0F);
  endtask

  task automatic t_shutdown();
    logic [7:0] v;
    wr(2'd2, 8'h81);
    pwm_en = 8'h82; shutdown_en = 1'b1;
    ticks(1);
    check("R4 pin7 input", pin_oe, 8'h03);
    rd(2'd2, v); check("R4 dir kept", v, 8'h81);
    pwm_en = 8'h00;
    ticks(1);
    check("R4 dir7 vetoed", pin_oe, 8'h01);
    shutdown_en = 1'b0;
    ticks(1);
    check("R4 released", pin_oe, 8'h81);
    wr(2'd2, 8'h00);
    ticks(4);
  endtask

  task automatic t_latency();
    logic [7:0] v;
    bus_addr = 2'd1;
    ticks(4);
    frc_en = 8'h04; frc_val = 8'h04;
    ticks(2);
    check("R5 not before third edge", bus_rdata, 8'h00);
    ticks(1);
    check("R5 after third edge", bus_rdata, 8'h04);
    frc_en = 8'h00; frc_val = 8'h00;
    ticks(4);
    rd(2'd1, v); check("R5 back low", v, 8'h00);
  endtask

  task automatic t_dir_rw();
    logic [7:0] v;
    wr(2'd2, 8'h5A); rd(2'd2, v); check("R7 readback 5A", v, 8'h5A);
    wr(2'd2, 8'hC3); rd(2'd2, v); check("R7 readback C3", v, 8'hC3);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_ignored();
    logic [7:0] v;
    wr(2'd0, 8'h3C);
    wr(2'd2, 8'h66);
    wr(2'd3, 8'hFF);
    wr(2'd1, 8'hFF);
    rd(2'd3, v); check("R8 unused reads 0", v, 8'h00);
    rd(2'd2, v); check("R8 dir untouched", v, 8'h66);
    check("R8 pin_out untouched", pin_out, 8'h3C);
    wr(2'd2, 8'hFF);
    rd(2'd0, v); check("R8 data untouched", v, 8'h3C);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_registered();
    logic [7:0] v;
    wr(2'd2, 8'h99);
    rd(2'd3, v);
    bus_addr = 2'd2;
    #1;
    check("R9 holds between edges", bus_rdata, 8'h00);
    ticks(1);
    check("R9 after edge", bus_rdata, 8'h99);
    wr(2'd2, 8'h00);
  endtask

  initial begin
    ticks(3);
    rst_n = 1'b1;
    ticks(2);
    t_reset();
    t_dir_drive();
    t_pwm();
    t_shutdown();
    t_latency();
    t_dir_rw();
    t_ignored();
    t_registered();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog (R1..R9 run) actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule